// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind a network receive path and stores accepted Ethernet frames into an 8 KiB circular byte buffer that software drains. Frames arrive one byte per beat with start and end markers; the class of the frame (broadcast or multicast) is given with the first byte and the CRC verdict with the last. Payload bytes go straight into memory four bytes past the current write offset. When the frame ends and passes every acceptance test, a 4-byte record header (status word, then length) is written at the record start. Only then does the write offset move to the next dword-aligned position.

Software learns where the producer is by reading the write offset. It returns space by writing its read offset minus 16 into the read-pointer register. The ring counts as empty when the biased read pointer plus 16 equals the write offset, modulo 8192. A record that starts near the end of the ring is not split: it continues linearly into a tail area past byte 8191, and the next record start wraps to the low end. A frame that would run into unread data is discarded and flagged. A sticky receive-OK flag, cleared by writing one, drives an event output.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the write offset reads 0, the read-pointer register reads 0xFFF0, the event-status and accept registers read 0, `ring_empty` is 1, `ring_full` is 0 and `rok_irq` is 0.
- R2: An accepted record at offset S has its header in the 32-bit memory word S/4: bits 15:0 hold the status (bit 0 = 1 for receive OK, bit 1 runt, bit 2 multicast, bit 3 broadcast) and bits 31:16 hold the byte count including the CRC. Payload byte k sits at byte address S+4+k, in word address/4 and byte lane address mod 4 (lane 0 = bits 7:0).
- R3: The write offset becomes (S + roundup4(4 + length)) mod 8192 on the clock edge that ends the last-byte beat of an accepted frame. It never changes at any other time, so it stays a multiple of 4.
- R4: A frame whose CRC flag is low at its last byte is dropped: the write offset is unchanged and no receive-OK is raised.
- R5: A frame shorter than 64 bytes is dropped unless accept bit 2 is set. When stored, it carries status bit 1.
- R6: A frame flagged broadcast (multicast) at its first byte is dropped unless accept bit 0 (bit 1) is set. When stored, it carries status bit 3 (bit 2). Unflagged frames are always accepted.
- R7: `ring_empty` is 1 exactly when (read pointer + 16) mod 8192 equals the write offset. `ring_full` is 1 when the free space from the write offset up to that read offset is 1520 bytes or less.
- R8: A frame whose rounded record size 4 + length would reach or pass the read offset is dropped, the write offset is unchanged, and event-status bit 4 is set.
- R9: A record that crosses byte 8192 continues at byte addresses 8192 and up (memory words 2048 and up) without splitting. The following write offset wraps modulo 8192.
- R10: Event-status bit 0 (mirrored on `rok_irq`) is set by each stored frame and holds until a register write with data bit 0 = 1; bit 4 clears the same way with data bit 4. A set and a clear in the same cycle leave the bit set.
- R11: A frame longer than 1516 bytes is dropped without setting the overflow bit.
- R12: The write-offset register (address 3) is read-only; writes to it have no effect.
- R13: The host memory port returns the word at `mem_raddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_crc_ok | input | 1 | CRC verdict, sampled with the last byte |
| rx_bcast | input | 1 | Broadcast destination, sampled with the first byte |
| rx_mcast | input | 1 | Multicast destination, sampled with the first byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 read pointer, 1 event status, 2 accept flags, 3 write offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| mem_raddr | input | 12 | Host read word address |
| mem_rdata | output | 32 | Host read word, one cycle later |
| rok_irq | output | 1 | Sticky receive-OK event |
| ring_empty | output | 1 | No unread record |
| ring_full | output | 1 | Less than a maximum record of free space |

## Verification
Two actions can fall in the same cycle: the commit of a frame, which raises receive-OK, and a software write-one that clears that same flag. The bench places the clearing register write on the beat that carries the frame's last byte, so both act on one clock edge. It then requires the flag to read as set, with the record and the write offset still correct. A second overlap is the pointer check against a read pointer software has just moved. The fill sequence settles this by moving the read pointer only between frames and then predicting exactly which frame overflows.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    RA_RDPTR  = 2'd0,
    RA_EVENT  = 2'd1,
    RA_ACCEPT = 2'd2,
    RA_WRPTR  = 2'd3
  } reg_addr_e;

  localparam int EV_OK_BIT   = 0;
  localparam int EV_OVF_BIT  = 4;
  localparam int ACC_BC_BIT  = 0;
  localparam int ACC_MC_BIT  = 1;
  localparam int ACC_RUNT_BIT = 2;
  localparam int HS_OK_BIT   = 0;
  localparam int HS_RUNT_BIT = 1;
  localparam int HS_MC_BIT   = 2;
  localparam int HS_BC_BIT   = 3;
endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
  parameter int WORDS = 2427,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          hw_en,
  input  logic [AW-1:0] hw_idx,
  input  logic [31:0]   hw_data,
  input  logic          bw_en,
  input  logic [AW-1:0] bw_idx,
  input  logic [1:0]    bw_lane,
  input  logic [7:0]    bw_data,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] store [WORDS];

  // header word and payload byte never target the same word in one cycle
  always_ff @(posedge clk) begin
    if (hw_en) begin
      store[hw_idx] <= hw_data;
    end
    if (bw_en) begin
      store[bw_idx][8*bw_lane +: 8] <= bw_data;
    end
    rd_data <= store[rd_idx];
  end
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int RAW     = 13,
  parameter int BIAS    = 16,
  parameter int REC_MAX = 1520
) (
  input  logic [15:0]  rdptr,
  input  logic [RAW-1:0] wrptr,
  output logic [RAW:0] space,
  output logic         empty,
  output logic         full
);
  localparam int RING_BYTES = 1 << RAW;

  logic [RAW-1:0] rd_off;
  logic [RAW-1:0] gap;

  always_comb begin
    rd_off = rdptr[RAW-1:0] + RAW'(BIAS);
    gap    = rd_off - wrptr;
    empty  = (gap == '0);
    space  = empty ? (RAW+1)'(RING_BYTES) : {1'b0, gap};
    full   = (space <= (RAW+1)'(REC_MAX));
  end
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int RAW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  input  logic           set_ok,
  input  logic           set_ovf,
  input  logic [RAW-1:0] wrptr,
  output logic [15:0]    rdptr,
  output logic [2:0]     accept,
  output logic           ev_ok,
  output logic           ev_ovf,
  output logic [15:0]    reg_rdata
);
  logic [15:0] rdptr_d;
  logic [2:0]  accept_d;
  logic        ev_ok_d, ev_ovf_d;
  logic        wr_rdptr, wr_event, wr_accept;

  always_comb begin
    wr_rdptr  = reg_wr && (reg_addr == RA_RDPTR);
    wr_event  = reg_wr && (reg_addr == RA_EVENT);
    wr_accept = reg_wr && (reg_addr == RA_ACCEPT);

    rdptr_d  = wr_rdptr  ? reg_wdata      : rdptr;
    accept_d = wr_accept ? reg_wdata[2:0] : accept;
    // a new event wins over a clear in the same cycle
    ev_ok_d  = set_ok  | (ev_ok  & ~(wr_event & reg_wdata[EV_OK_BIT]));
    ev_ovf_d = set_ovf | (ev_ovf & ~(wr_event & reg_wdata[EV_OVF_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdptr  <= 16'hFFF0;
      accept <= '0;
      ev_ok  <= 1'b0;
      ev_ovf <= 1'b0;
    end else begin
      rdptr  <= rdptr_d;
      accept <= accept_d;
      ev_ok  <= ev_ok_d;
      ev_ovf <= ev_ovf_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_RDPTR:  reg_rdata = rdptr;
      RA_EVENT: begin
        reg_rdata[EV_OK_BIT]  = ev_ok;
        reg_rdata[EV_OVF_BIT] = ev_ovf;
      end
      RA_ACCEPT: reg_rdata[2:0] = accept;
      default:   reg_rdata = 16'(wrptr);
    endcase
  end
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
  import rxr_pkg::*;
#(
  parameter int RAW     = 13,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1516,
  parameter int MIN_LEN = 64,
  parameter int BA_W    = 14,
  parameter int MEM_AW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_crc_ok,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic [2:0]        accept,
  input  logic [RAW:0]      space,
  output logic [RAW-1:0]    wrptr,
  output logic              hw_en,
  output logic [MEM_AW-1:0] hw_idx,
  output logic [31:0]       hw_data,
  output logic              bw_en,
  output logic [MEM_AW-1:0] bw_idx,
  output logic [1:0]        bw_lane,
  output logic [7:0]        bw_data,
  output logic              commit,
  output logic              ovf_evt
);
  localparam int SW = RAW + 1;

  logic             in_frm_q, in_frm_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             bc_q, bc_d, mc_q, mc_d;
  logic             rej_q, rej_d, big_q, big_d, ovf_q, ovf_d;
  logic [RAW-1:0]   wrptr_d;

  logic             beat, last;
  logic [LEN_W-1:0] cnt_cur, n;
  logic             bc_cur, mc_cur, rej_cur, big_cur, ovf_cur, runt;
  logic [SW-1:0]    need_raw, need;
  logic [BA_W-1:0]  baddr;
  logic [15:0]      hstat;

  always_comb begin
    beat    = rx_valid && (rx_sof || in_frm_q);
    last    = beat && rx_eof;
    cnt_cur = rx_sof ? '0 : cnt_q;
    bc_cur  = rx_sof ? rx_bcast : bc_q;
    mc_cur  = rx_sof ? rx_mcast : mc_q;
    rej_cur = rx_sof ? ((rx_bcast && !accept[ACC_BC_BIT]) ||
                        (rx_mcast && !accept[ACC_MC_BIT])) : rej_q;
    n       = cnt_cur + LEN_W'(1);
    big_cur = (!rx_sof && big_q) || (n > LEN_W'(MAX_LEN));
    // rounded record size if the frame ended with this byte
    need_raw = SW'(n) + SW'(7);
    need     = {need_raw[SW-1:2], 2'b00};
    ovf_cur  = (!rx_sof && ovf_q) || (need >= space);
    runt     = (n < LEN_W'(MIN_LEN));

    baddr   = BA_W'(wrptr) + BA_W'(4) + BA_W'(cnt_cur);
    bw_en   = beat && !rej_cur && !big_cur && !ovf_cur;
    bw_idx  = MEM_AW'(baddr >> 2);
    bw_lane = baddr[1:0];
    bw_data = rx_data;

    commit  = last && !rej_cur && !big_cur && !ovf_cur && rx_crc_ok &&
              (!runt || accept[ACC_RUNT_BIT]);
    ovf_evt = last && !rej_cur && !big_cur && ovf_cur;

    hstat = '0;
    hstat[HS_OK_BIT]   = 1'b1;
    hstat[HS_RUNT_BIT] = runt;
    hstat[HS_MC_BIT]   = mc_cur;
    hstat[HS_BC_BIT]   = bc_cur;
    hw_en   = commit;
    hw_idx  = MEM_AW'(wrptr >> 2);
    hw_data = {16'(n), hstat};

    wrptr_d  = commit ? (wrptr + need[RAW-1:0]) : wrptr;
    in_frm_d = beat ? !rx_eof : in_frm_q;
    cnt_d    = beat ? (big_cur ? LEN_W'(MAX_LEN) : n) : cnt_q;
    bc_d     = beat ? bc_cur  : bc_q;
    mc_d     = beat ? mc_cur  : mc_q;
    rej_d    = beat ? rej_cur : rej_q;
    big_d    = beat ? big_cur : big_q;
    ovf_d    = beat ? ovf_cur : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frm_q <= 1'b0;
      cnt_q    <= '0;
      bc_q     <= 1'b0;
      mc_q     <= 1'b0;
      rej_q    <= 1'b0;
      big_q    <= 1'b0;
      ovf_q    <= 1'b0;
      wrptr    <= '0;
    end else begin
      in_frm_q <= in_frm_d;
      cnt_q    <= cnt_d;
      bc_q     <= bc_d;
      mc_q     <= mc_d;
      rej_q    <= rej_d;
      big_q    <= big_d;
      ovf_q    <= ovf_d;
      wrptr    <= wrptr_d;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int RING_AW    = 13,
  parameter int TAIL_BYTES = 1516,
  parameter int MAX_LEN    = 1516,
  parameter int MIN_LEN    = 64,
  parameter int PTR_BIAS   = 16,
  parameter int MEM_AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_crc_ok,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [MEM_AW-1:0] mem_raddr,
  output logic [31:0]       mem_rdata,
  output logic              rok_irq,
  output logic              ring_empty,
  output logic              ring_full
);
  localparam int RING_BYTES = 1 << RING_AW;
  localparam int MEM_BYTES  = RING_BYTES + TAIL_BYTES;
  localparam int MEM_WORDS  = (MEM_BYTES + 3) / 4;
  localparam int BA_W       = $clog2(MEM_BYTES);
  localparam int LEN_W      = $clog2(MAX_LEN + 2);
  localparam int REC_MAX    = ((MAX_LEN + 4 + 3) / 4) * 4;

  logic [1:0]         rs_q;
  logic               rst_sync_n;
  logic [15:0]        rdptr;
  logic [2:0]         accept;
  logic               ev_ok, ev_ovf;
  logic [RING_AW:0]   space;
  logic [RING_AW-1:0] cbr_q;
  logic               hw_en, bw_en, commit, ovf_evt;
  logic [MEM_AW-1:0]  hw_idx, bw_idx;
  logic [31:0]        hw_data;
  logic [1:0]         bw_lane;
  logic [7:0]         bw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  rxr_regs #(.RAW(RING_AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .set_ok(commit), .set_ovf(ovf_evt), .wrptr(cbr_q),
    .rdptr(rdptr), .accept(accept), .ev_ok(ev_ok), .ev_ovf(ev_ovf),
    .reg_rdata(reg_rdata)
  );

  rxr_space #(.RAW(RING_AW), .BIAS(PTR_BIAS), .REC_MAX(REC_MAX)) u_space (
    .rdptr(rdptr), .wrptr(cbr_q),
    .space(space), .empty(ring_empty), .full(ring_full)
  );

  rxr_frame #(
    .RAW(RING_AW), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN),
    .BA_W(BA_W), .MEM_AW(MEM_AW)
  ) u_frame (
    .clk(clk), .rst_n(rst_sync_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_crc_ok(rx_crc_ok), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
    .accept(accept), .space(space), .wrptr(cbr_q),
    .hw_en(hw_en), .hw_idx(hw_idx), .hw_data(hw_data),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_lane(bw_lane), .bw_data(bw_data),
    .commit(commit), .ovf_evt(ovf_evt)
  );

  rxr_mem #(.WORDS(MEM_WORDS), .AW(MEM_AW)) u_mem (
    .clk(clk),
    .hw_en(hw_en), .hw_idx(hw_idx), .hw_data(hw_data),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_lane(bw_lane), .bw_data(bw_data),
    .rd_idx(mem_raddr), .rd_data(mem_rdata)
  );

  assign rok_irq = ev_ok;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int RAW = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_eof,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic [15:0]    reg_wdata,
  input logic           rok_irq,
  input logic           ring_empty,
  input logic           ring_full,
  input logic [RAW-1:0] cbr
);
  // R3: the write offset moves only on the edge after a last-byte beat
  p_cbr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eof) |=> $stable(cbr));

  // R3: record starts stay dword aligned
  p_cbr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cbr[1:0] == 2'b00);

  // R10: receive-OK holds until a write-one clear
  p_rok_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rok_irq && !(reg_wr && reg_addr == 2'd1 && reg_wdata[0])) |=> rok_irq);

  // R10: receive-OK rises only after a frame end
  p_rok_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rok_irq) |-> $past(rx_valid && rx_eof));

  // R7: empty and full cannot both be reported
  p_empty_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_empty && ring_full));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.RAW(RING_AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .rx_valid(rx_valid), .rx_eof(rx_eof),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rok_irq(rok_irq), .ring_empty(ring_empty), .ring_full(ring_full),
  .cbr(cbr_q)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_crc_ok, rx_bcast, rx_mcast;
  logic [7:0]  rx_data;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [11:0] mem_raddr;
  logic [31:0] mem_rdata;
  logic        rok_irq, ring_empty, ring_full;

  int checks = 0;
  int errors = 0;
  int exp_cbr = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_crc_ok(rx_crc_ok), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rok_irq(rok_irq), .ring_empty(ring_empty), .ring_full(ring_full)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run exceeded cycle limit, actual=%0d expected<=200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_mem(input int idx, output logic [31:0] v);
    @(negedge clk);
    mem_raddr = 12'(idx);
    @(negedge clk);
    #1 v = mem_rdata;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] b);
    logic [31:0] w;
    rd_mem(a / 4, w);
    b = 8'(w >> (8 * (a % 4)));
  endtask

  task automatic send_frame(input int len, input bit bc, input bit mc, input bit crc,
                            input int seed, input bit clr_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = pat(seed, i); rx_bcast = bc; rx_mcast = mc; rx_crc_ok = crc;
      if (clr_eof && i == len - 1) begin
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0001;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; reg_wr = 1'b0;
  endtask

  // send a frame expected to be stored, then check offset and record
  task automatic stored_frame(input int len, input bit bc, input bit mc, input int seed,
                              input string req, input bit clr_eof);
    int start;
    logic [15:0] v;
    logic [31:0] w;
    logic [7:0]  b;
    logic [15:0] st;
    start = exp_cbr;
    send_frame(len, bc, mc, 1'b1, seed, clr_eof);
    exp_cbr = (start + ((len + 7) / 4) * 4) % 8192;
    rd_reg(2'd3, v);
    chk({req, " R3 write offset"}, 32'(v), 32'(exp_cbr));
    st = 16'h0001 | (16'(len < 64) << 1) | (16'(mc) << 2) | (16'(bc) << 3);
    rd_mem(start / 4, w);
    chk({req, " R2 header"}, w, {16'(len), st});
    rd_byte(start + 4, b);
    chk({req, " R2 first byte"}, 32'(b), 32'(pat(seed, 0)));
    rd_byte(start + 3 + len, b);
    chk({req, " R2 last byte"}, 32'(b), 32'(pat(seed, len - 1)));
  endtask

  task automatic dropped_frame(input int len, input bit bc, input bit mc, input bit crc,
                               input int seed, input string req);
    logic [15:0] v;
    send_frame(len, bc, mc, crc, seed, 1'b0);
    rd_reg(2'd3, v);
    chk({req, " offset unchanged"}, 32'(v), 32'(exp_cbr));
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(2'd3, v); chk("R1 write offset", 32'(v), 32'h0);
    rd_reg(2'd0, v); chk("R1 read pointer", 32'(v), 32'hFFF0);
    rd_reg(2'd1, v); chk("R1 event status", 32'(v), 32'h0);
    rd_reg(2'd2, v); chk("R1 accept", 32'(v), 32'h0);
    chk("R1 empty", 32'(ring_empty), 32'h1);
    chk("R1 full", 32'(ring_full), 32'h0);
    chk("R1 rok", 32'(rok_irq), 32'h0);
  endtask

  task automatic t_unicast;
    stored_frame(64, 1'b0, 1'b0, 3, "R13 unicast64", 1'b0);
    chk("R10 rok set", 32'(rok_irq), 32'h1);
    chk("R7 not empty", 32'(ring_empty), 32'h0);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    wr_reg(2'd1, 16'h0010);
    chk("R10 bit4 write keeps rok", 32'(rok_irq), 32'h1);
    wr_reg(2'd1, 16'h0001);
    chk("R10 rok cleared", 32'(rok_irq), 32'h0);
    rd_reg(2'd1, v);
    chk("R10 status cleared", 32'(v), 32'h0);
  endtask

  task automatic t_odd;
    stored_frame(65, 1'b0, 1'b0, 11, "R2 odd65", 1'b0);
  endtask

  task automatic t_badcrc;
    wr_reg(2'd1, 16'h0001);
    dropped_frame(80, 1'b0, 1'b0, 1'b0, 5, "R4 bad crc");
    chk("R4 no rok", 32'(rok_irq), 32'h0);
  endtask

  task automatic t_runt;
    dropped_frame(20, 1'b0, 1'b0, 1'b1, 9, "R5 runt rejected");
    chk("R5 no rok", 32'(rok_irq), 32'h0);
    wr_reg(2'd2, 16'h0004);
    stored_frame(20, 1'b0, 1'b0, 9, "R5 runt accepted", 1'b0);
  endtask

  task automatic t_class;
    wr_reg(2'd2, 16'h0000);
    dropped_frame(64, 1'b1, 1'b0, 1'b1, 21, "R6 bcast rejected");
    dropped_frame(64, 1'b0, 1'b1, 1'b1, 22, "R6 mcast rejected");
    wr_reg(2'd2, 16'h0003);
    stored_frame(64, 1'b1, 1'b0, 23, "R6 bcast accepted", 1'b0);
    stored_frame(64, 1'b0, 1'b1, 24, "R6 mcast accepted", 1'b0);
  endtask

  task automatic t_same_cycle;
    logic [15:0] v;
    wr_reg(2'd1, 16'h0001);
    stored_frame(64, 1'b0, 1'b0, 31, "R10 clear with commit", 1'b1);
    chk("R10 set wins over clear", 32'(rok_irq), 32'h1);
    rd_reg(2'd1, v);
    chk("R10 status bit0 after overlap", 32'(v & 16'h1), 32'h1);
  endtask

  task automatic t_empty;
    wr_reg(2'd0, 16'(exp_cbr - 16));
    chk("R7 empty after pointer catch-up", 32'(ring_empty), 32'h1);
    chk("R7 not full when empty", 32'(ring_full), 32'h0);
  endtask

  task automatic t_fill;
    logic [15:0] v;
    logic [7:0]  b;
    int start;
    for (int k = 0; k < 5; k++) begin
      stored_frame(1516, 1'b0, 1'b0, 40 + k, "R7 fill", 1'b0);
    end
    chk("R7 full asserted", 32'(ring_full), 32'h1);
    rd_reg(2'd1, v);
    chk("R8 no overflow yet", 32'(v & 16'h10), 32'h0);
    dropped_frame(1516, 1'b0, 1'b0, 1'b1, 50, "R8 overflow frame");
    rd_reg(2'd1, v);
    chk("R8 overflow bit", 32'(v & 16'h10), 32'h10);
    start = exp_cbr;
    stored_frame(500, 1'b0, 1'b0, 60, "R9 wrap frame", 1'b0);
    chk("R9 record crossed into tail", 32'((start + 4 + 499) / 4 >= 2048), 32'h1);
    chk("R9 offset wrapped low", 32'(exp_cbr < start), 32'h1);
    rd_byte(8192, b);
    chk("R9 byte at ring end continues linearly", 32'(b), 32'(pat(60, 8192 - start - 4)));
    wr_reg(2'd1, 16'h0010);
    rd_reg(2'd1, v);
    chk("R10 overflow bit cleared", 32'(v & 16'h10), 32'h0);
    wr_reg(2'd0, 16'(exp_cbr - 16));
    chk("R7 full released", 32'(ring_full), 32'h0);
  endtask

  task automatic t_giant;
    logic [15:0] v;
    dropped_frame(1517, 1'b0, 1'b0, 1'b1, 70, "R11 giant");
    rd_reg(2'd1, v);
    chk("R11 no overflow flag", 32'(v & 16'h10), 32'h0);
    stored_frame(1516, 1'b0, 1'b0, 71, "R11 max length stored", 1'b0);
  endtask

  task automatic t_cbr_ro;
    logic [15:0] v;
    wr_reg(2'd3, 16'h0ABC);
    rd_reg(2'd3, v);
    chk("R12 write offset read-only", 32'(v), 32'(exp_cbr));
  endtask

  initial begin
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    rx_crc_ok = 1'b0; rx_bcast = 1'b0; rx_mcast = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; mem_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_unicast;
    t_clear;
    t_odd;
    t_badcrc;
    t_runt;
    t_class;
    t_same_cycle;
    t_empty;
    t_fill;
    t_giant;
    t_cbr_ro;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule